// File: doc/BRIEF.md
# Posted-Write Holdoff Gate

This block sits between a processor core's write-producing agents and the bus. It watches the external write cycles: their start, whether they are single or burst, and their ready strobes. On the ready strobe that ends each cycle it samples an active-low signal from system logic that reports whether the system's posted-write buffers have drained. If the buffers are still busy, a holdoff flag is raised. The input is then checked on every clock until it reports empty, and the flag drops on that edge.

While the flag is up, the block withholds grants from every agent whose action would write memory. These agents are store-buffer commits into the data cache, new bus writes, serializing operations, and interrupt responses flagged as writing memory. Interrupt requests flagged as not writing memory are passed straight through. Held requests wait in a small in-order queue and are released one per clock once the flag drops, so writes are delayed but never reordered. When the buffer-empty input is tied to its asserted level, the gate never holds anything back.

Top module: `wrbuf_hold_gate`

## Requirements
- R1: `bufempty_n` (0 = buffers empty, 1 = busy) is sampled only on the ready strobe that completes a write cycle. For a single cycle this is its first strobe; for a burst (`wcyc_burst`=1) it is the BURST_LEN-th strobe (fourth by default). Strobes on earlier beats have no effect. A completing strobe that sees 1 raises `hold_active` in the following cycle.
- R2: While `hold_active` is 1, `bufempty_n` is sampled on every clock. The first clock that sees 0 clears `hold_active` at that edge, and held requests become eligible in the next cycle.
- R3: While `hold_active` is 1, `st_commit_gnt`, `bus_wr_gnt` and `serial_gnt` stay 0, and their requests are held.
- R4: While `hold_active` is 1, an interrupt request with `irq_wr_mem[i]`=1 is not granted and is held.
- R5: An interrupt request with `irq_wr_mem[i]`=0 raises `irq_gnt[i]` in the same cycle, whatever the holdoff state.
- R6: Held requests are granted one per clock, in arrival order, starting the cycle after `hold_active` falls. A request that arrives while earlier ones are still queued is queued behind them.
- R7: With `hold_active` at 0 and nothing queued, a gated request is granted in the same cycle it is presented.
- R8: With `bufempty_n` held at 0, `hold_active` never rises, and grants follow requests with no added delay.
- R9: Synchronous active-high `rst` clears `hold_active`, the beat position of any write cycle in progress, and every queued request.
- R10: At most one gated (memory-writing) request is presented per cycle, and the number queued never exceeds QDEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wcyc_start | input | 1 | Pulse: an external write cycle begins |
| wcyc_burst | input | 1 | With `wcyc_start`: 1 = burst of BURST_LEN beats, 0 = single transfer |
| wcyc_rdy | input | 1 | Transfer-ready strobe of the current write cycle |
| bufempty_n | input | 1 | Active-low: 0 = external write buffers empty |
| st_commit_req | input | 1 | Store-buffer commit request pulse |
| bus_wr_req | input | 1 | Bus write request pulse |
| serial_req | input | 1 | Serializing operation request pulse |
| irq_req | input | NIRQ | Interrupt response request pulses |
| irq_wr_mem | input | NIRQ | Per interrupt: 1 = its handling writes memory |
| st_commit_gnt | output | 1 | Store commit grant |
| bus_wr_gnt | output | 1 | Bus write grant |
| serial_gnt | output | 1 | Serializing operation grant |
| irq_gnt | output | NIRQ | Interrupt response grants |
| hold_active | output | 1 | Holdoff flag |

## Verification
The bench targets the sampling point. It drives burst cycles whose early beats see a busy buffer; a design that sampled on every beat would stall too early there. It also ends a burst with the buffer empty, which a design that sampled only the first beat would misread. It fills the queue during a holdoff with a mix of sources and checks the release order one grant per cycle. A design that granted by fixed priority, or released everything at once, would show the wrong grant sequence. It presents a non-writing interrupt alongside a writing one during a holdoff. A design that gated on the source rather than on the write flag would drop the first or leak the second. Finally, it resets the block mid-burst and with a loaded queue. A design that kept the beat count or the queue across reset would stall after the wrong strobe or grant a stale request.

// File: rtl/wbh_pkg.sv
package wbh_pkg;

  // Fixed source positions inside the gated request/grant vectors.
  localparam int unsigned SRC_STORE  = 0;
  localparam int unsigned SRC_BUSWR  = 1;
  localparam int unsigned SRC_SERIAL = 2;
  localparam int unsigned SRC_IRQ0   = 3;

  // Beats remaining after the first one, for a cycle of the given kind.
  function automatic int unsigned beats_after_first(input logic burst,
                                                    input int unsigned burst_len);
    return burst ? (burst_len - 1) : 0;
  endfunction

  // Next holdoff state: raised only while sampling and the buffers are busy.
  function automatic logic next_hold(input logic sample_en, input logic bufempty_n);
    return sample_en & bufempty_n;
  endfunction

  // Circular pointer advance for a queue of any depth.
  function automatic int unsigned ptr_next(input int unsigned ptr,
                                           input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/wbh_beat_track.sv
module wbh_beat_track #(
  parameter int unsigned BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start_i,
  input  logic cyc_burst_i,
  input  logic rdy_i,
  output logic last_beat_o
);
  import wbh_pkg::*;

  localparam int unsigned CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic          active_q;
  logic [CW-1:0] left_q;
  logic          beat_seen;

  assign beat_seen   = active_q & rdy_i;
  assign last_beat_o = beat_seen & (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (cyc_start_i) begin
      active_q <= 1'b1;
      left_q   <= CW'(beats_after_first(cyc_burst_i, BURST_LEN));
    end else if (beat_seen) begin
      if (left_q == '0) begin
        active_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  // A new cycle starts only when the previous one has finished.
  assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    cyc_start_i |-> !active_q);

  // An early beat of a burst keeps the cycle open (no sampling yet).
  assert_early_beat_open_R1: assert property (@(posedge clk) disable iff (rst)
    (beat_seen && !last_beat_o) |=> active_q);

  // The completing beat closes the cycle.
  assert_last_beat_closes_R1: assert property (@(posedge clk) disable iff (rst)
    (last_beat_o && !cyc_start_i) |=> !active_q);

endmodule

// File: rtl/wbh_hold_sampler.sv
module wbh_hold_sampler (
  input  logic clk,
  input  logic rst,
  input  logic last_beat_i,
  input  logic bufempty_n,
  output logic hold_o
);
  import wbh_pkg::*;

  logic hold_q;
  logic sample_en;

  assign sample_en = last_beat_i | hold_q;
  assign hold_o    = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= next_hold(sample_en, bufempty_n);
    end
  end

  assert_busy_on_last_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (last_beat_i && bufempty_n) |=> hold_q);

  assert_idle_stays_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !last_beat_i) |=> !hold_q);

  assert_empty_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !bufempty_n) |=> !hold_q);

  assert_busy_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_q && bufempty_n) |=> hold_q);

endmodule

// File: rtl/wbh_order_fifo.sv
module wbh_order_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  import wbh_pkg::*;

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q;
  logic [AW-1:0] rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push;
  logic          do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= AW'(ptr_next(int'(wr_q), DEPTH));
      if (do_pop)  rd_q <= AW'(ptr_next(int'(rd_q), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    !(push_i && full_o && !pop_i));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    !(pop_i && empty_o));

  assert_push_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    (do_push && !do_pop) |=> !empty_o);

endmodule

// File: rtl/wrbuf_hold_gate.sv
module wrbuf_hold_gate #(
  parameter int unsigned NIRQ      = 4,
  parameter int unsigned QDEPTH    = 4,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wcyc_start,
  input  logic            wcyc_burst,
  input  logic            wcyc_rdy,
  input  logic            bufempty_n,
  input  logic            st_commit_req,
  input  logic            bus_wr_req,
  input  logic            serial_req,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_wr_mem,
  output logic            st_commit_gnt,
  output logic            bus_wr_gnt,
  output logic            serial_gnt,
  output logic [NIRQ-1:0] irq_gnt,
  output logic            hold_active
);
  import wbh_pkg::*;

  localparam int unsigned NSRC = SRC_IRQ0 + NIRQ;
  localparam int unsigned IDW  = $clog2(NSRC);

  logic            last_beat;
  logic            hold;
  logic [NSRC-1:0] gated_req;
  logic [NSRC-1:0] gated_gnt;
  logic [NIRQ-1:0] pass_irq;
  logic            any_gated;
  logic [IDW-1:0]  req_id;
  logic [IDW-1:0]  head_id;
  logic            q_empty;
  logic            q_full;
  logic            imm_go;
  logic            q_push;
  logic            q_pop;

  function automatic logic [IDW-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IDW-1:0] id;
    id = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) id = IDW'(i);
    end
    return id;
  endfunction

  wbh_beat_track #(.BURST_LEN(BURST_LEN)) u_beats (
    .clk         (clk),
    .rst         (rst),
    .cyc_start_i (wcyc_start),
    .cyc_burst_i (wcyc_burst),
    .rdy_i       (wcyc_rdy),
    .last_beat_o (last_beat)
  );

  wbh_hold_sampler u_sampler (
    .clk         (clk),
    .rst         (rst),
    .last_beat_i (last_beat),
    .bufempty_n  (bufempty_n),
    .hold_o      (hold)
  );

  // Gated request vector: fixed sources first, then memory-writing interrupts.
  assign gated_req[SRC_STORE]  = st_commit_req;
  assign gated_req[SRC_BUSWR]  = bus_wr_req;
  assign gated_req[SRC_SERIAL] = serial_req;
  for (genvar g = 0; g < NIRQ; g++) begin : g_irq_split
    assign gated_req[SRC_IRQ0 + g] = irq_req[g] & irq_wr_mem[g];
    assign pass_irq[g]             = irq_req[g] & ~irq_wr_mem[g];
  end

  assign any_gated = |gated_req;
  assign req_id    = lowest_set(gated_req);
  assign imm_go    = any_gated & ~hold & q_empty;
  assign q_push    = any_gated & ~imm_go;
  assign q_pop     = ~hold & ~q_empty;

  wbh_order_fifo #(.DEPTH(QDEPTH), .W(IDW)) u_order (
    .clk         (clk),
    .rst         (rst),
    .push_i      (q_push),
    .push_data_i (req_id),
    .pop_i       (q_pop),
    .head_o      (head_id),
    .empty_o     (q_empty),
    .full_o      (q_full)
  );

  always_comb begin
    gated_gnt = '0;
    if (imm_go) gated_gnt[req_id]  = 1'b1;
    if (q_pop)  gated_gnt[head_id] = 1'b1;
  end

  assign st_commit_gnt = gated_gnt[SRC_STORE];
  assign bus_wr_gnt    = gated_gnt[SRC_BUSWR];
  assign serial_gnt    = gated_gnt[SRC_SERIAL];
  assign irq_gnt       = gated_gnt[NSRC-1:SRC_IRQ0] | pass_irq;
  assign hold_active   = hold;

  // Nothing that writes memory is granted during a holdoff.
  assert_hold_blocks_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    hold |-> (gated_gnt[SRC_SERIAL:SRC_STORE] == '0));

  assert_hold_blocks_irq_R4: assert property (@(posedge clk) disable iff (rst)
    hold |-> (gated_gnt[NSRC-1:SRC_IRQ0] == '0));

  // Non-writing interrupts pass through in the same cycle.
  for (genvar k = 0; k < NIRQ; k++) begin : g_pass_chk
    assert_plain_irq_passes_R5: assert property (@(posedge clk) disable iff (rst)
      (irq_req[k] && !irq_wr_mem[k]) |-> irq_gnt[k]);
  end

  // Ordered release: at most one gated grant per clock.
  assert_single_release_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gated_gnt));

  // A queued request is released as soon as the holdoff is gone.
  assert_release_after_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!hold && !q_empty) |-> (gated_gnt != '0));

  // Free path: request granted in the cycle it appears.
  assert_free_path_R7: assert property (@(posedge clk) disable iff (rst)
    (!hold && q_empty && any_gated) |-> (gated_gnt == gated_req));

  // Requester contract: one memory-writing request per cycle.
  assert_one_gated_req_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(gated_req) <= 1);

  assert_queue_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    q_full |-> !(q_push && !q_pop));

endmodule

// File: tb/wrbuf_hold_gate_tb.sv
`timescale 1ns/1ps
module wrbuf_hold_gate_tb;

  localparam int NIRQ = 4;
  localparam int NV   = 35;

  logic            clk = 1'b0;
  logic            rst;
  logic            wcyc_start, wcyc_burst, wcyc_rdy, bufempty_n;
  logic            st_commit_req, bus_wr_req, serial_req;
  logic [NIRQ-1:0] irq_req, irq_wr_mem;
  logic            st_commit_gnt, bus_wr_gnt, serial_gnt, hold_active;
  logic [NIRQ-1:0] irq_gnt;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wrbuf_hold_gate u_dut (
    .clk(clk), .rst(rst),
    .wcyc_start(wcyc_start), .wcyc_burst(wcyc_burst), .wcyc_rdy(wcyc_rdy),
    .bufempty_n(bufempty_n),
    .st_commit_req(st_commit_req), .bus_wr_req(bus_wr_req), .serial_req(serial_req),
    .irq_req(irq_req), .irq_wr_mem(irq_wr_mem),
    .st_commit_gnt(st_commit_gnt), .bus_wr_gnt(bus_wr_gnt), .serial_gnt(serial_gnt),
    .irq_gnt(irq_gnt), .hold_active(hold_active)
  );

  // Vector: {tag[3:0], start, burst, rdy, bufempty_n, req[6:0], wrmem[3:0], exp_gnt[6:0], exp_hold}
  // req/gnt bit order: [6:3] irq3..irq0, [2] serial, [1] bus write, [0] store commit.
  localparam logic [26:0] VEC [NV] = '{
    {4'd8, 4'b0001, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 0  idle
    {4'd7, 4'b0001, 7'b0000001, 4'b0000, 7'b0000001, 1'b0}, // 1  R7 store free
    {4'd1, 4'b1001, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 2  single start
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 3  R1 last beat busy
    {4'd3, 4'b0001, 7'b0000001, 4'b0000, 7'b0000000, 1'b1}, // 4  R3 store held
    {4'd5, 4'b0001, 7'b0011000, 4'b0010, 7'b0001000, 1'b1}, // 5  R5 irq0 passes, R4 irq1 held
    {4'd3, 4'b0001, 7'b0000100, 4'b0000, 7'b0000000, 1'b1}, // 6  R3 serial held
    {4'd2, 4'b0000, 7'b0000010, 4'b0000, 7'b0000000, 1'b1}, // 7  R2 empty seen, bus write queued
    {4'd6, 4'b0001, 7'b0000000, 4'b0000, 7'b0000001, 1'b0}, // 8  R6 store first
    {4'd6, 4'b0001, 7'b0000000, 4'b0000, 7'b0010000, 1'b0}, // 9  R6 irq1
    {4'd6, 4'b0001, 7'b0000000, 4'b0000, 7'b0000100, 1'b0}, // 10 R6 serial
    {4'd6, 4'b0001, 7'b0000000, 4'b0000, 7'b0000010, 1'b0}, // 11 R6 bus write
    {4'd7, 4'b0001, 7'b0000010, 4'b0000, 7'b0000010, 1'b0}, // 12 R7 free again
    {4'd1, 4'b1101, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 13 burst start
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 14 R1 beat1 busy ignored
    {4'd1, 4'b0011, 7'b0000001, 4'b0000, 7'b0000001, 1'b0}, // 15 R1 beat2 ignored
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 16 R1 beat3 ignored
    {4'd1, 4'b0010, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 17 R1 beat4 empty
    {4'd1, 4'b0001, 7'b0000001, 4'b0000, 7'b0000001, 1'b0}, // 18 R1 no stall
    {4'd1, 4'b1100, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 19 burst start
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 20
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 21
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 22
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 23 R1 beat4 busy
    {4'd3, 4'b0001, 7'b0000100, 4'b0000, 7'b0000000, 1'b1}, // 24 R3 serial held
    {4'd2, 4'b0000, 7'b0000000, 4'b0000, 7'b0000000, 1'b1}, // 25 R2 clear
    {4'd2, 4'b0001, 7'b0000000, 4'b0000, 7'b0000100, 1'b0}, // 26 R2 serial released
    {4'd8, 4'b1000, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 27 R8 tied empty
    {4'd8, 4'b0010, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 28
    {4'd8, 4'b0000, 7'b0000010, 4'b0000, 7'b0000010, 1'b0}, // 29 R8 no delay
    {4'd1, 4'b1001, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 30
    {4'd1, 4'b0011, 7'b0000000, 4'b0000, 7'b0000000, 1'b0}, // 31
    {4'd4, 4'b0001, 7'b1000000, 4'b1000, 7'b0000000, 1'b1}, // 32 R4 irq3 held
    {4'd2, 4'b0000, 7'b0000000, 4'b0000, 7'b0000000, 1'b1}, // 33
    {4'd4, 4'b0000, 7'b0000000, 4'b0000, 7'b1000000, 1'b0}  // 34 R4 irq3 released
  };

  function automatic logic [6:0] gnt_now();
    return {irq_gnt, serial_gnt, bus_wr_gnt, st_commit_gnt};
  endfunction

  task automatic check(input int tag, input string what,
                       input logic [6:0] exp_g, input logic exp_h);
    n_chk++;
    if (gnt_now() !== exp_g) begin
      n_fail++;
      $display("FAIL R%0d %s grants actual=%b expected=%b", tag, what, gnt_now(), exp_g);
    end
    n_chk++;
    if (hold_active !== exp_h) begin
      n_fail++;
      $display("FAIL R%0d %s hold actual=%b expected=%b", tag, what, hold_active, exp_h);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [6:0] rq, input logic [3:0] wm);
    {wcyc_start, wcyc_burst, wcyc_rdy, bufempty_n} = ctl;
    {irq_req, serial_req, bus_wr_req, st_commit_req} = rq;
    irq_wr_mem = wm;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    drive(4'b0000, 7'b0, 4'b0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(4'b0000, 7'b0, 4'b0);
    repeat (3) @(negedge clk);
    #2;
    check(9, "reset state", 7'b0, 1'b0); // R9
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][22:19], VEC[v][18:12], VEC[v][11:8]);
      #2;
      check(int'(VEC[v][26:23]), $sformatf("vector %0d", v), VEC[v][7:1], VEC[v][0]);
      @(negedge clk);
    end

    // R9: reset with a holdoff up and a request queued.
    drive(4'b1001, 7'b0, 4'b0); @(negedge clk);
    drive(4'b0011, 7'b0, 4'b0); @(negedge clk);
    drive(4'b0001, 7'b0000001, 4'b0); @(negedge clk);
    drive(4'b0001, 7'b0, 4'b0); rst = 1'b1; @(negedge clk);
    rst = 1'b0; #2;
    check(9, "after reset hold cleared", 7'b0, 1'b0);
    drive(4'b0001, 7'b0, 4'b0); #2;
    check(9, "queue flushed", 7'b0, 1'b0);
    @(negedge clk);
    drive(4'b0000, 7'b0000010, 4'b0); #2;
    check(9, "free after reset", 7'b0000010, 1'b0);

    // R9 with R1: reset mid-burst discards the beat position.
    idle_cycle();
    drive(4'b1100, 7'b0, 4'b0); @(negedge clk);
    drive(4'b0010, 7'b0, 4'b0); @(negedge clk);
    drive(4'b0010, 7'b0, 4'b0); rst = 1'b1; @(negedge clk);
    rst = 1'b0;
    drive(4'b1000, 7'b0, 4'b0); @(negedge clk);
    drive(4'b0011, 7'b0, 4'b0); #2;
    check(9, "single after burst reset", 7'b0, 1'b0);
    @(negedge clk);
    drive(4'b0000, 7'b0, 4'b0); #2;
    check(1, "single last beat stalls", 7'b0, 1'b1);
    @(negedge clk);
    drive(4'b0000, 7'b0, 4'b0); #2;
    check(2, "cleared next", 7'b0, 1'b0);

    // R5 during a holdoff on every non-writing line.
    drive(4'b1001, 7'b0, 4'b0); @(negedge clk);
    drive(4'b0011, 7'b0, 4'b0); @(negedge clk);
    drive(4'b0001, 7'b1111000, 4'b0000); #2;
    check(5, "all plain irqs pass", 7'b1111000, 1'b1);
    @(negedge clk);
    drive(4'b0000, 7'b0, 4'b0); @(negedge clk);
    #2;
    check(2, "idle after clear", 7'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule